// File: doc/BRIEF.md
# Shared interrupt pin controller

This block merges three families of events onto one interrupt pin. Four transmit sources, eight receive sources and one wake source each feed their own status register. Four receive sources belong to channel A and four to channel B. The wake source fires when the oscillator becomes stable after power-down is released. Each family also has an enable register, and one configuration bit selects the polarity of the pin. A host reaches all of these registers through a plain port with an address, write data, a write strobe, read data and a read strobe.

An operating-mode input decides which families may drive the pin. In transmit mode every receive source is silenced. In either receive mode every transmit source is silenced. In single-channel receive mode the channel-B receive sources are silenced as well. The wake source is never silenced. Masking acts only on the pin. The status registers keep recording every event, so a host can poll them without using the pin, and the enable registers keep their contents across mode changes.

A two-state machine, QUIET and ACTIVE, produces the pin. The transition QUIET to ACTIVE is taken when the combined request is high, and ACTIVE to QUIET is taken when it is low. In ACTIVE the pad output-enable is high and the level equals the polarity bit. In QUIET the output-enable is low and the level is the inverse of the polarity bit. This models open-drain drive when the pin is active low and open-source drive when it is active high.

Top module: `irqc_top`

## Requirements
- R1: After reset, all enable and status registers and the polarity bit read 0, and the pin is released: irq_oe_o=0 and irq_o=1.
- R2: The registers sit at these addresses, and any unused bit reads 0:
  - configuration 0x05: bit 0 is the polarity, 1 meaning active high.
  - receive enable 0x07 and receive status 0x08: bits 3:0 are channel A, bits 7:4 are channel B.
  - transmit enable 0x0D and transmit status 0x0E: bits 3:0.
  - wake enable 0x1C and wake status 0x1D: bit 0.
  - reg_rdata_o shows the addressed register in the same cycle.
- R3: A source event in cycle k sets its status bit whether or not it is enabled, and the bit reads back from cycle k+1.
- R4: A read strobe on 0x08, 0x0E or 0x1D clears that status register at the end of the read cycle.
- R5: An event that arrives in the same cycle as a clearing read of its register keeps its bit set.
- R6: The pin asserts one cycle after the OR of all enabled, unmasked status bits becomes 1, and releases one cycle after that OR becomes 0.
- R7: In mode_i=00 (transmit), receive status never asserts the pin.
- R8: In mode_i=01 (dual receive) and mode_i=1x (single receive), transmit status never asserts the pin.
- R9: In mode_i=1x, channel-B receive bits (7:4) never assert the pin, even when they are enabled.
- R10: Enable registers change only on writes and keep their values across mode changes.
- R11: An enabled, pending wake status asserts the pin in every mode.
- R12: While asserted, irq_oe_o=1 and irq_o equals the polarity bit. While released, irq_oe_o=0 and irq_o is its inverse. A polarity write takes effect from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 2 | Operating mode: 00 transmit, 01 dual receive, 1x single receive |
| tx_evt_i | input | 4 | Transmit event pulses |
| rx_evt_i | input | 8 | Receive event pulses, 3:0 channel A, 7:4 channel B |
| wake_evt_i | input | 1 | Oscillator-stable event pulse |
| reg_addr_i | input | 5 | Register address |
| reg_wr_i | input | 1 | Write strobe |
| reg_wdata_i | input | 8 | Write data |
| reg_rd_i | input | 1 | Read strobe (clears status registers) |
| reg_rdata_o | output | 8 | Read data for reg_addr_i |
| irq_o | output | 1 | Logical pin level |
| irq_oe_o | output | 1 | Pad output-enable |

## Verification
Read data is due in the same cycle as the read strobe. A status bit is due one cycle after its event. The pin responds one cycle after a status, enable or mode change reaches the request: two cycles after an event, and two cycles after a clearing read. A polarity change shows on the level in the cycle after the write. The scoreboard tags each expected item with the cycle it is due in, and the monitor compares it mid-cycle in exactly that cycle, so a result that comes early or late counts as a failure.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int ADDR_W = 5;

    localparam logic [ADDR_W-1:0] ADR_CFG   = 5'h05;
    localparam logic [ADDR_W-1:0] ADR_RX_EN = 5'h07;
    localparam logic [ADDR_W-1:0] ADR_RX_ST = 5'h08;
    localparam logic [ADDR_W-1:0] ADR_TX_EN = 5'h0D;
    localparam logic [ADDR_W-1:0] ADR_TX_ST = 5'h0E;
    localparam logic [ADDR_W-1:0] ADR_WK_EN = 5'h1C;
    localparam logic [ADDR_W-1:0] ADR_WK_ST = 5'h1D;

    typedef enum logic [1:0] {
        OPM_TX          = 2'b00,
        OPM_RX_DUAL     = 2'b01,
        OPM_RX_SOLO     = 2'b10,
        OPM_RX_SOLO_ALT = 2'b11
    } opmode_e;

    typedef enum logic {
        PIN_QUIET  = 1'b0,
        PIN_ACTIVE = 1'b1
    } pin_state_e;

endpackage

// File: rtl/irqc_event_bank.sv
module irqc_event_bank #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt_i,
    input  logic         rd_clr_i,
    input  logic         wr_en_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] en_o,
    output logic [W-1:0] stat_o
);

    logic [W-1:0] en_q;
    logic [W-1:0] stat_q;
    logic [W-1:0] stat_kept;

    always_comb begin
        stat_kept = rd_clr_i ? '0 : stat_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= '0;
            stat_q <= '0;
        end else begin
            if (wr_en_i) begin
                en_q <= wdata_i;
            end
            stat_q <= stat_kept | evt_i;
        end
    end

    assign en_o   = en_q;
    assign stat_o = stat_q;

    AST_EVT_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i != '0) |=> ((stat_o & $past(evt_i)) == $past(evt_i))); // R3
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr_i && evt_i == '0) |=> (stat_o == '0)); // R4
    AST_EVT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr_i && evt_i != '0) |=> (stat_o == $past(evt_i))); // R5
    AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> $stable(en_o)); // R10

endmodule

// File: rtl/irqc_mode_mask.sv
module irqc_mode_mask
    import irqc_pkg::*;
#(
    parameter int TX_W    = 4,
    parameter int RX_CH_W = 4
) (
    input  opmode_e                mode_i,
    output logic [TX_W-1:0]        tx_pass_o,
    output logic [2*RX_CH_W-1:0]   rx_pass_o
);

    localparam int RX_W = 2 * RX_CH_W;

    always_comb begin
        tx_pass_o = '1;
        rx_pass_o = '1;
        unique case (mode_i)
            OPM_TX: begin
                rx_pass_o = '0;
            end
            OPM_RX_DUAL: begin
                tx_pass_o = '0;
            end
            OPM_RX_SOLO, OPM_RX_SOLO_ALT: begin
                tx_pass_o                   = '0;
                rx_pass_o[RX_W-1:RX_CH_W]   = '0;
            end
        endcase
    end

endmodule

// File: rtl/irqc_pin_fsm.sv
module irqc_pin_fsm
    import irqc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    input  logic pol_i,
    output logic pin_o,
    output logic oe_o
);

    pin_state_e state_q;
    pin_state_e state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PIN_QUIET;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PIN_QUIET:  if (req_i)  state_d = PIN_ACTIVE;
            PIN_ACTIVE: if (!req_i) state_d = PIN_QUIET;
        endcase
    end

    always_comb begin
        unique case (state_q)
            PIN_QUIET: begin
                oe_o  = 1'b0;
                pin_o = ~pol_i;
            end
            PIN_ACTIVE: begin
                oe_o  = 1'b1;
                pin_o = pol_i;
            end
        endcase
    end

    AST_ASSERT_ON_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_i |=> oe_o); // R6
    AST_RELEASE_ON_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !req_i |=> !oe_o); // R6

endmodule

// File: rtl/irqc_top.sv
module irqc_top
    import irqc_pkg::*;
#(
    parameter int TX_W    = 4,
    parameter int RX_CH_W = 4,
    parameter int DATA_W  = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          mode_i,
    input  logic [TX_W-1:0]     tx_evt_i,
    input  logic [2*RX_CH_W-1:0] rx_evt_i,
    input  logic                wake_evt_i,
    input  logic [ADDR_W-1:0]   reg_addr_i,
    input  logic                reg_wr_i,
    input  logic [DATA_W-1:0]   reg_wdata_i,
    input  logic                reg_rd_i,
    output logic [DATA_W-1:0]   reg_rdata_o,
    output logic                irq_o,
    output logic                irq_oe_o
);

    localparam int RX_W = 2 * RX_CH_W;

    opmode_e          mode;
    logic [TX_W-1:0]  tx_en, tx_st, tx_pass;
    logic [RX_W-1:0]  rx_en, rx_st, rx_pass;
    logic             wk_en, wk_st;
    logic             pol_q;
    logic             req;

    assign mode = opmode_e'(mode_i);

    irqc_event_bank #(.W(TX_W)) u_tx_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt_i   (tx_evt_i),
        .rd_clr_i(reg_rd_i && reg_addr_i == ADR_TX_ST),
        .wr_en_i (reg_wr_i && reg_addr_i == ADR_TX_EN),
        .wdata_i (reg_wdata_i[TX_W-1:0]),
        .en_o    (tx_en),
        .stat_o  (tx_st)
    );

    irqc_event_bank #(.W(RX_W)) u_rx_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt_i   (rx_evt_i),
        .rd_clr_i(reg_rd_i && reg_addr_i == ADR_RX_ST),
        .wr_en_i (reg_wr_i && reg_addr_i == ADR_RX_EN),
        .wdata_i (reg_wdata_i[RX_W-1:0]),
        .en_o    (rx_en),
        .stat_o  (rx_st)
    );

    irqc_event_bank #(.W(1)) u_wk_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt_i   (wake_evt_i),
        .rd_clr_i(reg_rd_i && reg_addr_i == ADR_WK_ST),
        .wr_en_i (reg_wr_i && reg_addr_i == ADR_WK_EN),
        .wdata_i (reg_wdata_i[0]),
        .en_o    (wk_en),
        .stat_o  (wk_st)
    );

    irqc_mode_mask #(.TX_W(TX_W), .RX_CH_W(RX_CH_W)) u_mask (
        .mode_i   (mode),
        .tx_pass_o(tx_pass),
        .rx_pass_o(rx_pass)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pol_q <= 1'b0;
        end else if (reg_wr_i && reg_addr_i == ADR_CFG) begin
            pol_q <= reg_wdata_i[0];
        end
    end

    always_comb begin
        req = (|(tx_st & tx_en & tx_pass)) |
              (|(rx_st & rx_en & rx_pass)) |
              (wk_st & wk_en);
    end

    always_comb begin
        reg_rdata_o = '0;
        unique case (reg_addr_i)
            ADR_CFG:   reg_rdata_o[0]        = pol_q;
            ADR_RX_EN: reg_rdata_o[RX_W-1:0] = rx_en;
            ADR_RX_ST: reg_rdata_o[RX_W-1:0] = rx_st;
            ADR_TX_EN: reg_rdata_o[TX_W-1:0] = tx_en;
            ADR_TX_ST: reg_rdata_o[TX_W-1:0] = tx_st;
            ADR_WK_EN: reg_rdata_o[0]        = wk_en;
            ADR_WK_ST: reg_rdata_o[0]        = wk_st;
            default:   reg_rdata_o           = '0;
        endcase
    end

    irqc_pin_fsm u_pin (
        .clk  (clk),
        .rst_n(rst_n),
        .req_i(req),
        .pol_i(pol_q),
        .pin_o(irq_o),
        .oe_o (irq_oe_o)
    );

    AST_RX_SILENT_IN_TX: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 2'b00 && (tx_st & tx_en) == '0 && !(wk_st && wk_en)) |=> !irq_oe_o); // R7
    AST_TX_SILENT_IN_RX: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i != 2'b00 && (rx_st & rx_en) == '0 && !(wk_st && wk_en)) |=> !irq_oe_o); // R8
    AST_CHB_SILENT_SOLO: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i[1] && (rx_st[RX_CH_W-1:0] & rx_en[RX_CH_W-1:0]) == '0 && !(wk_st && wk_en))
        |=> !irq_oe_o); // R9
    AST_WAKE_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (wk_st && wk_en) |=> irq_oe_o); // R11
    AST_LEVEL_WHEN_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        irq_oe_o |-> (irq_o == pol_q)); // R12
    AST_LEVEL_WHEN_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_oe_o |-> (irq_o == !pol_q)); // R12

endmodule

// File: tb/tb_irqc_top.sv
module tb_irqc_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode_i = 2'b00;
    logic [3:0] tx_evt_i = '0;
    logic [7:0] rx_evt_i = '0;
    logic       wake_evt_i = 1'b0;
    logic [4:0] reg_addr_i = '0;
    logic       reg_wr_i = 1'b0;
    logic [7:0] reg_wdata_i = '0;
    logic       reg_rd_i = 1'b0;
    logic [7:0] reg_rdata_o;
    logic       irq_o;
    logic       irq_oe_o;

    irqc_top dut (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i),
        .tx_evt_i(tx_evt_i), .rx_evt_i(rx_evt_i), .wake_evt_i(wake_evt_i),
        .reg_addr_i(reg_addr_i), .reg_wr_i(reg_wr_i), .reg_wdata_i(reg_wdata_i),
        .reg_rd_i(reg_rd_i), .reg_rdata_o(reg_rdata_o),
        .irq_o(irq_o), .irq_oe_o(irq_oe_o)
    );

    always #2 clk = ~clk;

    typedef struct {
        string      tag;
        int         kind;
        logic [7:0] exp;
        int         due;
    } item_t;

    item_t sb[$];
    int    cyc = 0;
    int    checks = 0;
    int    errors = 0;
    bit    done = 1'b0;
    item_t mon_it;
    logic [7:0] mon_act;

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: pops each expected item in the cycle it is due
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].due <= cyc) begin
            mon_it  = sb.pop_front();
            mon_act = (mon_it.kind == 0) ? reg_rdata_o : {6'b0, irq_oe_o, irq_o};
            checks++;
            if (mon_act !== mon_it.exp || mon_it.due != cyc) begin
                errors++;
                $display("FAIL %s actual=%h expected=%h (due %0d, now %0d)",
                         mon_it.tag, mon_act, mon_it.exp, mon_it.due, cyc);
            end
        end
    end

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic push(string tag, int kind, logic [7:0] exp, int due);
        item_t it;
        it.tag = tag; it.kind = kind; it.exp = exp; it.due = due;
        sb.push_back(it);
    endtask

    task automatic wr(logic [4:0] a, logic [7:0] d);
        reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
        tick();
        reg_wr_i = 1'b0;
    endtask

    task automatic rd(string tag, logic [4:0] a, logic [7:0] exp);
        reg_rd_i = 1'b1; reg_addr_i = a;
        push(tag, 0, exp, cyc);
        tick();
        reg_rd_i = 1'b0;
    endtask

    task automatic pulse(logic [3:0] t, logic [7:0] r, logic w);
        tx_evt_i = t; rx_evt_i = r; wake_evt_i = w;
        tick();
        tx_evt_i = '0; rx_evt_i = '0; wake_evt_i = 1'b0;
    endtask

    // pin encoding {oe, level}
    task automatic pin_next(string tag, logic [1:0] exp);
        push(tag, 1, {6'b0, exp}, cyc + 1);
        tick();
    endtask

    task automatic pin_now(string tag, logic [1:0] exp);
        push(tag, 1, {6'b0, exp}, cyc);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired actual=hung expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state
        rd("R1 rx enable", 5'h07, 8'h00);
        rd("R1 tx enable", 5'h0D, 8'h00);
        rd("R1 wake enable", 5'h1C, 8'h00);
        rd("R1 config", 5'h05, 8'h00);
        rd("R1 rx status", 5'h08, 8'h00);
        pin_now("R1 pin released", 2'b01);
        rd("R2 unmapped reads zero", 5'h00, 8'h00);

        // R3 latch while disabled, R4 clear on read
        pulse(4'b0101, 8'h00, 1'b0);
        pin_next("R3 disabled tx keeps pin idle", 2'b01);
        rd("R3 tx status polled", 5'h0E, 8'h05);
        rd("R4 tx status cleared", 5'h0E, 8'h00);

        // R6 pin assert / release
        wr(5'h0D, 8'h01);
        rd("R2 tx enable readback", 5'h0D, 8'h01);
        pulse(4'b0001, 8'h00, 1'b0);
        pin_next("R6 tx pin asserts active low", 2'b10);
        rd("R6 tx status before clear", 5'h0E, 8'h01);
        pin_next("R6 pin releases after clear", 2'b01);

        // R7 rx masked in tx mode
        wr(5'h07, 8'hFF);
        pulse(4'b0000, 8'h11, 1'b0);
        pin_next("R7 rx masked in tx mode", 2'b01);
        rd("R3 rx status latched in tx mode", 5'h08, 8'h11);
        pulse(4'b0000, 8'h11, 1'b0);
        // R10 enables survive mode change
        mode_i = 2'b01;
        rd("R10 rx enable kept", 5'h07, 8'hFF);
        rd("R10 tx enable kept", 5'h0D, 8'h01);
        pin_now("R8 pending rx fires in dual rx", 2'b10);
        rd("R4 rx status read", 5'h08, 8'h11);
        pin_next("R4 pin releases after rx clear", 2'b01);
        pulse(4'b0000, 8'h20, 1'b0);
        pin_next("R9 channel B fires in dual mode", 2'b10);
        rd("R2 rx channel B bit", 5'h08, 8'h20);
        pin_next("R6 release", 2'b01);

        // R9 single-channel mode
        mode_i = 2'b10;
        pulse(4'b0000, 8'h40, 1'b0);
        pin_next("R9 channel B silent in single mode", 2'b01);
        rd("R9 channel B still latched", 5'h08, 8'h40);
        pulse(4'b0000, 8'h02, 1'b0);
        pin_next("R9 channel A fires in single mode", 2'b10);
        rd("R9 channel A status", 5'h08, 8'h02);
        pin_next("R9 release", 2'b01);

        // R8 tx masked in rx mode
        pulse(4'b0001, 8'h00, 1'b0);
        pin_next("R8 tx masked in rx mode", 2'b01);
        rd("R8 tx status latched", 5'h0E, 8'h01);

        // R11 wake in rx mode
        wr(5'h1C, 8'h01);
        pulse(4'b0000, 8'h00, 1'b1);
        pin_next("R11 wake fires in rx mode", 2'b10);
        rd("R4 wake status read", 5'h1D, 8'h01);
        pin_next("R4 wake release", 2'b01);
        rd("R4 wake status cleared", 5'h1D, 8'h00);

        // R12 polarity
        wr(5'h05, 8'h01);
        pin_now("R12 idle level high-polarity", 2'b00);
        rd("R12 config readback", 5'h05, 8'h01);
        mode_i = 2'b00;
        pulse(4'b0000, 8'h00, 1'b1);
        pin_next("R11 wake fires in tx mode active high", 2'b11);

        // R5 event during clearing read
        reg_rd_i = 1'b1; reg_addr_i = 5'h1D; wake_evt_i = 1'b1;
        push("R5 wake read returns old", 0, 8'h01, cyc);
        tick();
        reg_rd_i = 1'b0; wake_evt_i = 1'b0;
        pin_now("R5 pin stays asserted", 2'b11);
        rd("R5 wake kept set", 5'h1D, 8'h01);
        reg_rd_i = 1'b1; reg_addr_i = 5'h0E; tx_evt_i = 4'b0010;
        push("R5 tx read returns old", 0, 8'h00, cyc);
        tick();
        reg_rd_i = 1'b0; tx_evt_i = '0;
        rd("R5 tx kept set", 5'h0E, 8'h02);
        pin_next("R12 release level low", 2'b00);

        repeat (4) tick();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule